// File: doc/BRIEF.md
# Subset RV32 Instruction Decoder

This block is a purely combinational decoder for 32-bit instruction words drawn from a small RV32 subset. It recognises nine operations: add-immediate, set-less-than-immediate, word store, word load, signed byte load, unsigned byte load, jump-and-link, CSR read-and-clear with an immediate mask, and the instruction-fetch fence. Every other encoding is reported as illegal.

For each word it produces a one-hot operation select and the three register indices. It also produces a sign-extended 32-bit immediate assembled for the operation's format, the raw 12-bit CSR address field and the 5-bit unsigned mask field. A register-write enable follows the destination register. A flag marks the jump as the end of sequential flow, and a second flag marks the fence as needing a pipeline flush. A pipeline front end places it between fetch and the register-read stage. The register file, memory, ALU and PC logic all live outside it.

Top module: `subset_rv_decoder`

## Requirements
- R1: Bits 6:0 (opcode) and 14:12 (funct3) select exactly one `op_sel_o` bit, with bit indices as follows: 0 add-imm (0010011/000), 1 slt-imm (0010011/010), 2 store-word (0100011/010), 3 load-word (0000011/010), 4 load-byte (0000011/000), 5 load-byte-unsigned (0000011/100), 6 jump-and-link (1101111, any funct3), 7 csr-clear-imm (1110011/111), 8 fetch-fence (0001111/001).
- R2: Any other opcode/funct3 pair drives `illegal_o` high. It also drives `op_sel_o`, `rf_we_o`, `end_seq_o`, `flush_o` and `imm_o` to zero. A recognised word drives `illegal_o` low.
- R3: `rd_o` is bits 11:7, `rs1_o` is bits 19:15 and `rs2_o` is bits 24:20 of every word, whatever the operation.
- R4: For add-imm, slt-imm, the three loads and the fetch-fence, `imm_o` is bits 31:20 sign-extended from bit 31.
- R5: For store-word, `imm_o` is {bits 31:25, bits 11:7} sign-extended from bit 31.
- R6: For jump-and-link, `imm_o` is the 21-bit value {bit 31, bits 19:12, bit 20, bits 30:21, 0} sign-extended from bit 31, so bit 0 is always zero.
- R7: `csr_addr_o` is bits 31:20 and `zimm_o` is bits 19:15 of every word. For csr-clear-imm, `imm_o` is `zimm_o` zero-extended.
- R8: `rf_we_o` is high only for add-imm, slt-imm, the loads, jump-and-link and csr-clear-imm, and only when `rd_o` is not zero.
- R9: `end_seq_o` is high only for jump-and-link. `flush_o` is high only for fetch-fence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr_i | input | 32 | Instruction word to decode |
| op_sel_o | output | 9 | One-hot operation select (index per R1) |
| rd_o | output | 5 | Destination register index |
| rs1_o | output | 5 | First source register index |
| rs2_o | output | 5 | Second source register index |
| imm_o | output | 32 | Assembled, extended immediate |
| csr_addr_o | output | 12 | CSR address field |
| zimm_o | output | 5 | Unsigned CSR mask field |
| illegal_o | output | 1 | Encoding not in the subset |
| rf_we_o | output | 1 | Register-file write enable |
| end_seq_o | output | 1 | Operation ends sequential flow |
| flush_o | output | 1 | Operation requires a pipeline flush |

## Verification
The block holds no state, so a fault in the classifier or the immediate mux shows on the ports for the same word that triggers it. A bad opcode/funct3 table entry shows as a zero or two-hot `op_sel_o`, or a wrongly raised `illegal_o`. A mis-wired immediate format shows as a wrong `imm_o` for only that operation class. Random words biased toward the legal encodings, plus directed words with rd zero, sign bits set and near-miss funct3 values, make each such fault visible within a few vectors.

// File: rtl/sdec_pkg.sv
package sdec_pkg;

  localparam int XLEN    = 32;
  localparam int REG_W   = 5;
  localparam int NUM_OPS = 9;
  localparam int OPC_W   = 7;
  localparam int F3_W    = 3;
  localparam int CSR_W   = 12;

  // one-hot select positions
  localparam int OP_ADDI   = 0;
  localparam int OP_SLTI   = 1;
  localparam int OP_SW     = 2;
  localparam int OP_LW     = 3;
  localparam int OP_LB     = 4;
  localparam int OP_LBU    = 5;
  localparam int OP_JAL    = 6;
  localparam int OP_CSRRCI = 7;
  localparam int OP_FENCEI = 8;

  localparam logic [OPC_W-1:0] OPC_ALUI  = 7'b0010011;
  localparam logic [OPC_W-1:0] OPC_STORE = 7'b0100011;
  localparam logic [OPC_W-1:0] OPC_LOAD  = 7'b0000011;
  localparam logic [OPC_W-1:0] OPC_JAL   = 7'b1101111;
  localparam logic [OPC_W-1:0] OPC_SYS   = 7'b1110011;
  localparam logic [OPC_W-1:0] OPC_FENCE = 7'b0001111;

  // operations that write the register file
  localparam logic [NUM_OPS-1:0] WRITE_MASK =
    (NUM_OPS'(1) << OP_ADDI) | (NUM_OPS'(1) << OP_SLTI) |
    (NUM_OPS'(1) << OP_LW)   | (NUM_OPS'(1) << OP_LB)   |
    (NUM_OPS'(1) << OP_LBU)  | (NUM_OPS'(1) << OP_JAL)  |
    (NUM_OPS'(1) << OP_CSRRCI);

  typedef enum logic [2:0] {
    IMM_NONE = 3'd0,
    IMM_I    = 3'd1,
    IMM_S    = 3'd2,
    IMM_J    = 3'd3,
    IMM_Z    = 3'd4
  } imm_kind_e;

  function automatic logic [OPC_W-1:0] op_opcode(input int idx);
    case (idx)
      OP_ADDI, OP_SLTI:      op_opcode = OPC_ALUI;
      OP_SW:                 op_opcode = OPC_STORE;
      OP_LW, OP_LB, OP_LBU:  op_opcode = OPC_LOAD;
      OP_JAL:                op_opcode = OPC_JAL;
      OP_CSRRCI:             op_opcode = OPC_SYS;
      default:               op_opcode = OPC_FENCE;
    endcase
  endfunction

  function automatic logic [F3_W-1:0] op_funct3(input int idx);
    case (idx)
      OP_ADDI, OP_LB:          op_funct3 = 3'b000;
      OP_SLTI, OP_SW, OP_LW:   op_funct3 = 3'b010;
      OP_LBU:                  op_funct3 = 3'b100;
      OP_CSRRCI:               op_funct3 = 3'b111;
      OP_FENCEI:               op_funct3 = 3'b001;
      default:                 op_funct3 = 3'b000;
    endcase
  endfunction

  // jump has no funct3 field
  function automatic logic op_uses_funct3(input int idx);
    op_uses_funct3 = (idx != OP_JAL);
  endfunction

  function automatic logic [XLEN-1:0] imm_i_fmt(input logic [31:7] w);
    imm_i_fmt = {{(XLEN-12){w[31]}}, w[31:20]};
  endfunction

  function automatic logic [XLEN-1:0] imm_s_fmt(input logic [31:7] w);
    imm_s_fmt = {{(XLEN-12){w[31]}}, w[31:25], w[11:7]};
  endfunction

  function automatic logic [XLEN-1:0] imm_j_fmt(input logic [31:7] w);
    imm_j_fmt = {{(XLEN-21){w[31]}}, w[31], w[19:12], w[20], w[30:21], 1'b0};
  endfunction

  function automatic logic [XLEN-1:0] imm_z_fmt(input logic [31:7] w);
    imm_z_fmt = {{(XLEN-REG_W){1'b0}}, w[19:15]};
  endfunction

endpackage

// File: rtl/sdec_class.sv
module sdec_class
  import sdec_pkg::*;
(
  input  logic [OPC_W-1:0]   opcode_i,
  input  logic [F3_W-1:0]    funct3_i,
  output logic [NUM_OPS-1:0] op_sel_o,
  output logic               legal_o,
  output imm_kind_e          imm_kind_o
);

  for (genvar g = 0; g < NUM_OPS; g++) begin : g_op
    localparam logic [OPC_W-1:0] MY_OPC = op_opcode(g);
    localparam logic [F3_W-1:0]  MY_F3  = op_funct3(g);
    localparam logic             USE_F3 = op_uses_funct3(g);
    logic opc_hit, f3_hit;
    assign opc_hit     = (opcode_i == MY_OPC);
    assign f3_hit      = !USE_F3 || (funct3_i == MY_F3);
    assign op_sel_o[g] = opc_hit && f3_hit;
  end

  assign legal_o = |op_sel_o;

  logic is_ifmt, is_sfmt, is_jfmt, is_zfmt;
  assign is_ifmt = op_sel_o[OP_ADDI] | op_sel_o[OP_SLTI] | op_sel_o[OP_LW] |
                   op_sel_o[OP_LB]   | op_sel_o[OP_LBU]  | op_sel_o[OP_FENCEI];
  assign is_sfmt = op_sel_o[OP_SW];
  assign is_jfmt = op_sel_o[OP_JAL];
  assign is_zfmt = op_sel_o[OP_CSRRCI];

  always_comb begin
    if (is_ifmt)      imm_kind_o = IMM_I;
    else if (is_sfmt) imm_kind_o = IMM_S;
    else if (is_jfmt) imm_kind_o = IMM_J;
    else if (is_zfmt) imm_kind_o = IMM_Z;
    else              imm_kind_o = IMM_NONE;
  end

endmodule

// File: rtl/sdec_imm.sv
module sdec_imm
  import sdec_pkg::*;
(
  input  logic [31:7]     word_i,
  input  imm_kind_e       kind_i,
  output logic [XLEN-1:0] imm_o
);

  always_comb begin
    case (kind_i)
      IMM_I:   imm_o = imm_i_fmt(word_i);
      IMM_S:   imm_o = imm_s_fmt(word_i);
      IMM_J:   imm_o = imm_j_fmt(word_i);
      IMM_Z:   imm_o = imm_z_fmt(word_i);
      default: imm_o = '0;
    endcase
  end

endmodule

// File: rtl/sdec_ctrl.sv
module sdec_ctrl
  import sdec_pkg::*;
(
  input  logic [NUM_OPS-1:0] op_sel_i,
  input  logic [REG_W-1:0]   rd_i,
  output logic               rf_we_o,
  output logic               end_seq_o,
  output logic               flush_o
);

  logic wants_write, rd_is_zero;
  assign wants_write = |(op_sel_i & WRITE_MASK);
  assign rd_is_zero  = (rd_i == '0);
  assign rf_we_o     = wants_write && !rd_is_zero;
  assign end_seq_o   = op_sel_i[OP_JAL];
  assign flush_o     = op_sel_i[OP_FENCEI];

endmodule

// File: rtl/subset_rv_decoder.sv
module subset_rv_decoder
  import sdec_pkg::*;
(
  input  logic [31:0]        instr_i,
  output logic [NUM_OPS-1:0] op_sel_o,
  output logic [REG_W-1:0]   rd_o,
  output logic [REG_W-1:0]   rs1_o,
  output logic [REG_W-1:0]   rs2_o,
  output logic [XLEN-1:0]    imm_o,
  output logic [CSR_W-1:0]   csr_addr_o,
  output logic [REG_W-1:0]   zimm_o,
  output logic               illegal_o,
  output logic               rf_we_o,
  output logic               end_seq_o,
  output logic               flush_o
);

  logic [OPC_W-1:0] opcode_w;
  logic [F3_W-1:0]  funct3_w;
  logic             legal_w;
  imm_kind_e        imm_kind_w;

  assign opcode_w   = instr_i[6:0];
  assign funct3_w   = instr_i[14:12];
  assign rd_o       = instr_i[11:7];
  assign rs1_o      = instr_i[19:15];
  assign rs2_o      = instr_i[24:20];
  assign csr_addr_o = instr_i[31:20];
  assign zimm_o     = instr_i[19:15];

  sdec_class u_class (
    .opcode_i   (opcode_w),
    .funct3_i   (funct3_w),
    .op_sel_o   (op_sel_o),
    .legal_o    (legal_w),
    .imm_kind_o (imm_kind_w)
  );

  sdec_imm u_imm (
    .word_i (instr_i[31:7]),
    .kind_i (imm_kind_w),
    .imm_o  (imm_o)
  );

  sdec_ctrl u_ctrl (
    .op_sel_i  (op_sel_o),
    .rd_i      (instr_i[11:7]),
    .rf_we_o   (rf_we_o),
    .end_seq_o (end_seq_o),
    .flush_o   (flush_o)
  );

  assign illegal_o = !legal_w;

endmodule

// File: rtl/sdec_checker.sv
module sdec_checker
  import sdec_pkg::*;
(
  input logic [31:0]        instr_i,
  input logic [NUM_OPS-1:0] op_sel_o,
  input logic [REG_W-1:0]   rd_o,
  input logic [XLEN-1:0]    imm_o,
  input logic [REG_W-1:0]   zimm_o,
  input logic               illegal_o,
  input logic               rf_we_o,
  input logic               end_seq_o,
  input logic               flush_o
);

  always_comb begin
    p_onehot_r1: assert ($onehot0(op_sel_o))
      else $error("op_sel not one-hot");
    p_illegal_quiet_r2: assert (!illegal_o ||
        (op_sel_o == '0 && !rf_we_o && !end_seq_o && !flush_o && imm_o == '0))
      else $error("illegal word has side outputs");
    p_legal_sel_r2: assert (illegal_o || op_sel_o != '0)
      else $error("legal word without select");
    p_jal_even_r6: assert (!op_sel_o[OP_JAL] || !imm_o[0])
      else $error("jump offset odd");
    p_zimm_ext_r7: assert (!op_sel_o[OP_CSRRCI] || imm_o == {{(XLEN-REG_W){1'b0}}, zimm_o})
      else $error("csr immediate not zero-extended");
    p_we_rd0_r8: assert (!(rd_o == '0 && rf_we_o))
      else $error("write enable with rd zero");
    p_we_store_r8: assert (!(op_sel_o[OP_SW] || op_sel_o[OP_FENCEI]) || !rf_we_o)
      else $error("store/fence writes");
    p_flow_r9: assert ((end_seq_o == op_sel_o[OP_JAL]) && (flush_o == op_sel_o[OP_FENCEI])
                       && !(end_seq_o && flush_o) && (instr_i[6:0] == OPC_JAL || !end_seq_o))
      else $error("flow flags wrong");
  end

endmodule

bind subset_rv_decoder sdec_checker u_chk (
  .instr_i   (instr_i),
  .op_sel_o  (op_sel_o),
  .rd_o      (rd_o),
  .imm_o     (imm_o),
  .zimm_o    (zimm_o),
  .illegal_o (illegal_o),
  .rf_we_o   (rf_we_o),
  .end_seq_o (end_seq_o),
  .flush_o   (flush_o)
);

// File: tb/subset_rv_decoder_test.sv
`timescale 1ns/1ps
module subset_rv_decoder_test;

  logic clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  logic [31:0] instr;
  logic [8:0]  op_sel;
  logic [4:0]  rd, rs1, rs2, zimm;
  logic [31:0] imm;
  logic [11:0] csr_addr;
  logic        illegal, rf_we, end_seq, flush;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  subset_rv_decoder uut (
    .instr_i(instr), .op_sel_o(op_sel), .rd_o(rd), .rs1_o(rs1), .rs2_o(rs2),
    .imm_o(imm), .csr_addr_o(csr_addr), .zimm_o(zimm), .illegal_o(illegal),
    .rf_we_o(rf_we), .end_seq_o(end_seq), .flush_o(flush)
  );

  // expected op index, -1 for not in subset
  function automatic int exp_op(input logic [31:0] w);
    logic [9:0] key;
    key = {w[14:12], w[6:0]};
    if (w[6:0] == 7'h6F) return 6;
    case (key)
      10'b000_0010011: return 0;
      10'b010_0010011: return 1;
      10'b010_0100011: return 2;
      10'b010_0000011: return 3;
      10'b000_0000011: return 4;
      10'b100_0000011: return 5;
      10'b111_1110011: return 7;
      10'b001_0001111: return 8;
      default:         return -1;
    endcase
  endfunction

  function automatic logic [31:0] sext(input logic [31:0] v, input int bits);
    logic signed [31:0] t;
    t = $signed(v << (32 - bits));
    return 32'(t >>> (32 - bits));
  endfunction

  function automatic logic [31:0] exp_imm(input logic [31:0] w);
    int op;
    logic [31:0] raw;
    op = exp_op(w);
    raw = '0;
    case (op)
      0, 1, 3, 4, 5, 8: return sext(32'(w >> 20), 12);
      2: begin
        raw = (32'(w >> 25) << 5) | 32'(w[11:7]);
        return sext(raw, 12);
      end
      6: begin
        raw = (32'(w[31]) << 20) | (32'(w[19:12]) << 12) |
              (32'(w[20]) << 11) | (32'(w[30:21]) << 1);
        return sext(raw, 21);
      end
      7: return 32'(w[19:15]);
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
    n_tests++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s %s instr=%h actual=%h expected=%h", tag, what, instr, act, expv);
    end
  endtask

  task automatic apply(input logic [31:0] w);
    int op;
    logic [8:0] sel;
    logic we;
    @(negedge clk);
    instr = w;
    #1;
    op  = exp_op(w);
    sel = (op < 0) ? 9'h0 : 9'(1 << op);
    we  = (op >= 0) && (op != 2) && (op != 8) && (w[11:7] != 5'd0);
    check("R1", "op_sel",   32'(op_sel), 32'(sel));
    check("R2", "illegal",  32'(illegal), 32'(op < 0));
    check("R3", "rd",       32'(rd),  32'(w[11:7]));
    check("R3", "rs1",      32'(rs1), 32'(w[19:15]));
    check("R3", "rs2",      32'(rs2), 32'(w[24:20]));
    check(op == 2 ? "R5" : op == 6 ? "R6" : op == 7 ? "R7" : op < 0 ? "R2" : "R4",
          "imm", imm, exp_imm(w));
    check("R7", "csr_addr", 32'(csr_addr), 32'(w[31:20]));
    check("R7", "zimm",     32'(zimm), 32'(w[19:15]));
    check("R8", "rf_we",    32'(rf_we), 32'(we));
    check("R9", "end_seq",  32'(end_seq), 32'(op == 6));
    check("R9", "flush",    32'(flush), 32'(op == 8));
  endtask

  function automatic logic [31:0] make_word(input int cls, input logic [31:0] rnd);
    logic [6:0] opc [9];
    logic [2:0] f3 [9];
    opc = '{7'h13, 7'h13, 7'h23, 7'h03, 7'h03, 7'h03, 7'h6F, 7'h73, 7'h0F};
    f3  = '{3'd0, 3'd2, 3'd2, 3'd2, 3'd0, 3'd4, 3'd0, 3'd7, 3'd1};
    if (cls >= 9) return rnd;
    if (cls == 6) return {rnd[31:7], opc[cls]};
    return {rnd[31:15], f3[cls], rnd[11:7], opc[cls]};
  endfunction

  initial begin
    instr = 32'h0;
    process_seed();
    // reset-state style check: all-zero word is not in the subset (R2)
    apply(32'h0000_0000);
    // directed corners
    apply(32'h0000_0013);            // add-imm rd=0: no write (R8)
    apply(32'hFFF0_8093);            // add-imm imm=-1, rd=1 (R4)
    apply(32'h8000_2013);            // slt-imm most negative (R4)
    apply(32'hFE11_AFA3);            // store imm all ones (R5)
    apply(32'h7E00_2023);            // store positive (R5)
    apply(32'h8000_006F);            // jump, only sign bit (R6)
    apply(32'h7FFF_F0EF);            // jump largest positive (R6)
    apply(32'h0010_00EF);            // jump bit20 -> imm[11] (R6)
    apply(32'h3000_7073);            // csr clear, zimm=0, rd=0 (R7, R8)
    apply(32'hFFFF_F0F3);            // csr clear zimm=31 rd=1 (R7)
    apply(32'h0000_100F);            // fetch fence (R9)
    apply(32'h0000_000F);            // fence funct3=0: illegal (R2)
    apply(32'h0000_1003);            // load funct3=001: illegal (R2)
    apply(32'h0000_6013);            // alu-imm funct3=110: illegal (R2)
    apply(32'h0000_0033);            // register-register opcode: illegal (R2)
    apply(32'h0000_0023);            // store funct3=000: illegal (R2)
    apply(32'h0000_6073);            // csr funct3=110: illegal (R2)
    apply(32'hFFF8_4283);            // load-byte-unsigned imm -1 (R4)
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      int cls;
      r = $urandom;
      cls = int'($urandom_range(0, 10));
      apply(make_word(cls, r));
    end
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  task automatic process_seed();
    void'($urandom(32'd20240611));
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired, actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule